// File: doc/BRIEF.md
# Edge-Qualified Event Counter

This block counts falling edges on an asynchronous event line and raises an interrupt pulse each time a programmed number of edges has been seen. The line is first brought into the clock domain by a synchroniser. It is then sampled only on clock cycles where the machine-cycle enable is high. A level is accepted only once it has been seen on a minimum number of consecutive samples (two by default). A falling edge is the accepted level changing from high to low. Because each level must last two samples, the fastest event rate the block follows is one edge every four machine cycles.

Software writes a compare value one byte at a time, low byte first and then high byte. Each byte lands in the compare register straight away, with no shadow copy. While the run control is high, every qualified falling edge advances the count. The edge that would make the count equal to the compare value instead clears the count to zero and fires a one-cycle interrupt. Counting then carries on from zero with the next qualified edge. Dropping the run control clears the count and the qualification state. No pin is driven; only the count and the interrupt leave the block.

Top module: `evt_counter`

## Requirements
- R1: After synchronous reset the count reads 0, the interrupt is low and the compare register holds all ones (0xFFFF).
- R2: While running, each qualified falling edge adds one to the count. A qualified falling edge is the input held high for at least two consecutive machine-cycle samples, then low for at least two. After reset or stop the accepted level starts low, so a qualified high must come before the first counted edge.
- R3: A low pulse that is seen on fewer than two consecutive machine-cycle samples does not change the count.
- R4: A high pulse that is seen on fewer than two consecutive machine-cycle samples between two long low periods does not change the count.
- R5: The input is sampled only on cycles where the machine-cycle enable is 1. With the enable held at 0, input edges do not change the count.
- R6: On the qualified edge where count plus one equals the compare value, the count clears to 0 and the interrupt is 1 for that cycle. The count therefore runs from 0 to compare−1. A compare value of 0 means 65536 edges.
- R7: After a match clears the count, the next qualified falling edge makes the count 1.
- R8: A write with the write enable high stores the data byte into the compare lane picked by the lane select: select 0 is bits 7:0 and select 1 is bits 15:8. The write takes effect on the next clock edge, including while running.
- R9: While the run control is 0, the count is held at 0, the interrupt stays low and input edges are not counted. After a restart the first qualified edge gives a count of 1.
- R10: The interrupt is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run control; 0 stops and clears |
| mc_en_i | input | 1 | Machine-cycle enable; the input is sampled when 1 |
| evt_i | input | 1 | Asynchronous event input |
| wr_en_i | input | 1 | Compare byte write strobe |
| wr_sel_i | input | 1 | Compare lane select (0 low byte, 1 high byte) |
| wr_data_i | input | 8 | Compare byte data |
| cnt_o | output | 16 | Current count |
| irq_o | output | 1 | One-cycle match interrupt |

## Verification
The bench sends one-cycle glitches of each polarity. A qualifier that reacted to a single sample would count a spurious edge on either glitch. It checks the match boundary: a design that compared the stored count instead of the next count would show the compare value for a cycle, or clear one edge late. It programs a high byte so that the lane positions can be told apart, and lowers the compare value while running to prove the write has no shadow copy. Stop and restart, and a held-off machine-cycle enable, show whether stale qualification state or ungated sampling would produce extra counts. Random compare values, sampling rates and pulse widths are checked against a model of count and interrupt totals.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Accepted level of the qualified event line
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } evc_lvl_e;

    // Saturating increment for a small run-length counter
    function automatic logic [7:0] evc_sat_inc(input logic [7:0] val, input logic [7:0] lim);
        return (val >= lim) ? lim : val + 8'd1;
    endfunction

    // A qualified change from high to low is a counted edge
    function automatic logic evc_is_fall(input evc_lvl_e prev, input logic now);
        return (prev == LVL_HIGH) && (now == 1'b0);
    endfunction

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/evc_qual.sv
module evc_qual
    import evc_pkg::*;
#(
    parameter int QUAL_N = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic tick_i,
    input  logic din_i,
    output logic fall_o
);
    evc_lvl_e   lvl_q;
    logic       cand_q;
    logic [7:0] run_q;
    logic [7:0] run_nx;
    logic       accept;
    logic       fall_q;

    always_comb begin
        run_nx = (din_i == cand_q) ? evc_sat_inc(run_q, 8'(QUAL_N)) : 8'd1;
        accept = (run_nx >= 8'(QUAL_N)) && (din_i != logic'(lvl_q));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            lvl_q  <= LVL_LOW;
            cand_q <= 1'b0;
            run_q  <= '0;
            fall_q <= 1'b0;
        end else begin
            fall_q <= 1'b0;
            if (tick_i) begin
                cand_q <= din_i;
                run_q  <= run_nx;
                if (accept) begin
                    lvl_q  <= evc_lvl_e'(din_i);
                    fall_q <= evc_is_fall(lvl_q, din_i);
                end
            end
        end
    end

    assign fall_o = fall_q;
endmodule

// File: rtl/evc_core.sv
module evc_core #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = CNT_W / BYTE_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    input  logic              fall_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             hit;
    logic             irq_q;

    // One write lane per compare byte, no shadow copy
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        always_ff @(posedge clk_i) begin
            if (rst_i)
                cmp_q[b*BYTE_W +: BYTE_W] <= '1;
            else if (wr_en_i && (wr_sel_i == SEL_W'(b)))
                cmp_q[b*BYTE_W +: BYTE_W] <= wr_data_i;
        end
    end

    always_comb begin
        cnt_nx = cnt_q + 1'b1;
        hit    = (cnt_nx == cmp_q);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (fall_i) begin
                if (hit) begin
                    cnt_q <= '0;
                    irq_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_nx;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign cmp_o = cmp_q;
    assign irq_o = irq_q;
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W       = 16,
    parameter int BYTE_W      = 8,
    parameter int QUAL_N      = 2,
    parameter int SYNC_STAGES = 2,
    localparam int LANES      = CNT_W / BYTE_W,
    localparam int SEL_W      = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    input  logic              mc_en_i,
    input  logic              evt_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_o
);
    logic             evt_sync;
    logic             fall;
    logic [CNT_W-1:0] cmp_w;

    evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (evt_i),
        .q_o   (evt_sync)
    );

    evc_qual #(.QUAL_N(QUAL_N)) u_qual (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (!run_i),
        .tick_i (mc_en_i),
        .din_i  (evt_sync),
        .fall_o (fall)
    );

    evc_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (run_i),
        .fall_i    (fall),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .cnt_o     (cnt_o),
        .cmp_o     (cmp_w),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             run_i,
    input logic             mc_en_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] cmp_i,
    input logic             irq_i
);
    // R1: state right after reset
    p_reset_state_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (cnt_i == '0 && !irq_i && cmp_i == '1));

    // R2: the count only steps by one or returns to zero
    p_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + 1'b1 || cnt_i == '0));

    // R5: an advance traces back to a sampled machine cycle
    p_mc_gate_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_i != $past(cnt_i) && cnt_i != '0) |-> $past(mc_en_i, 2));

    // R6: the interrupt goes with a cleared count
    p_irq_clear_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_i |-> (cnt_i == '0));

    // R9: stopped means cleared and quiet
    p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> (cnt_i == '0 && !irq_i));

    // R10: interrupt is a single-cycle pulse
    p_irq_single_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_i |=> !irq_i);
endmodule

bind evt_counter evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_i   (run_i),
    .mc_en_i (mc_en_i),
    .cnt_i   (cnt_o),
    .cmp_i   (cmp_w),
    .irq_i   (irq_o)
);

// File: tb/evt_counter_tb.sv
module evt_counter_tb;
    localparam int CLK_P = 10;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        run_i = 1'b0;
    logic        mc_en_i = 1'b0;
    logic        evt_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [0:0]  wr_sel_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic [15:0] cnt_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int irq_seen = 0;
    int irq_wide = 0;
    int mc_div = 1;
    bit mc_off = 1'b0;
    bit prev_irq = 1'b0;

    // bench model
    int unsigned cmp_m = 32'hFFFF;
    int unsigned cnt_m = 0;
    int irq_m = 0;

    evt_counter u_dut (
        .clk_i(clk_i), .rst_i(rst_i), .run_i(run_i), .mc_en_i(mc_en_i),
        .evt_i(evt_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .cnt_o(cnt_o), .irq_o(irq_o)
    );

    always #(CLK_P/2) clk_i = ~clk_i;

    // machine-cycle enable generator
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk_i); #1;
            ph = (ph + 1 >= mc_div) ? 0 : ph + 1;
            mc_en_i = !mc_off && (ph == 0);
        end
    end

    // interrupt monitor
    initial begin
        forever begin
            @(negedge clk_i);
            if (irq_o) irq_seen++;
            if (irq_o && prev_irq) irq_wide++;
            prev_irq = irq_o;
        end
    end

    function automatic int unsigned target(input int unsigned c);
        return (c == 0) ? 32'd65536 : c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        @(negedge clk_i);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        evt_i = lvl;
        repeat (n) @(posedge clk_i);
        #1;
    endtask

    function automatic int qlen();
        return 3 * mc_div + 6;
    endfunction

    // one qualified falling edge, with model update
    task automatic edge_evt(input int extra);
        hold(1'b1, qlen() + extra);
        hold(1'b0, qlen() + extra);
        if (run_i) begin
            if (cnt_m + 1 == target(cmp_m)) begin
                cnt_m = 0;
                irq_m++;
            end else begin
                cnt_m = cnt_m + 1;
            end
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(posedge clk_i); #1;
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(posedge clk_i); #1;
        wr_en_i = 1'b0;
        if (sel) cmp_m = (cmp_m & 32'h00FF) | (32'(d) << 8);
        else     cmp_m = (cmp_m & 32'hFF00) | 32'(d);
    endtask

    task automatic stop_start();
        run_i = 1'b0;
        repeat (3) @(posedge clk_i); #1;
        cnt_m = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk_i); #1;
        rst_i = 1'b0;

        // R1
        check("R1 count after reset", int'(cnt_o), 0);
        check("R1 irq after reset", int'(irq_o), 0);

        // R2 basic counting, default compare
        run_i = 1'b1;
        for (int i = 0; i < 5; i++) edge_evt(0);
        check("R2 five edges", int'(cnt_o), 5);
        check("R1 default compare gives no irq", irq_seen, 0);

        // R3 short low glitch
        hold(1'b1, qlen());
        hold(1'b0, 1);
        hold(1'b1, qlen());
        check("R3 low glitch ignored", int'(cnt_o), 5);
        hold(1'b0, qlen());
        cnt_m = cnt_m + 1;
        check("R3 real edge after glitch", int'(cnt_o), 6);

        // R4 short high glitch
        hold(1'b1, 1);
        hold(1'b0, qlen());
        check("R4 high glitch ignored", int'(cnt_o), 6);

        // R5 machine-cycle enable held off
        mc_off = 1'b1;
        hold(1'b1, 20); hold(1'b0, 20);
        mc_off = 1'b0;
        hold(1'b0, qlen());
        check("R5 no count without machine cycles", int'(cnt_o), 6);

        // R9 stop clears, edges ignored while stopped
        stop_start();
        check("R9 count cleared on stop", int'(cnt_o), 0);
        edge_evt(0);
        edge_evt(0);
        check("R9 edges ignored while stopped", int'(cnt_o), 0);
        check("R9 no irq while stopped", irq_seen, 0);
        run_i = 1'b1;
        edge_evt(0);
        check("R9 first edge after restart", int'(cnt_o), 1);

        // R6 / R7 / R8 low-byte compare
        stop_start();
        wr(1'b0, 8'd3); wr(1'b1, 8'd0);
        run_i = 1'b1;
        edge_evt(0); edge_evt(0);
        check("R6 before match", int'(cnt_o), 2);
        edge_evt(0);
        check("R6 cleared on match", int'(cnt_o), 0);
        check("R6 one irq on match", irq_seen, 1);
        edge_evt(0);
        check("R7 resumes after clear", int'(cnt_o), 1);

        // R8 write while running takes effect at once
        wr(1'b0, 8'd10);
        edge_evt(0); edge_evt(0);
        check("R8 raised compare in effect", int'(cnt_o), 3);
        wr(1'b0, 8'd5);
        edge_evt(0);
        check("R8 count before lowered compare", int'(cnt_o), 4);
        edge_evt(0);
        check("R8 lowered compare matches", int'(cnt_o), 0);
        check("R8 irq total", irq_seen, 2);

        // R8 high-byte lane: compare 0x0102 = 258
        stop_start();
        wr(1'b0, 8'h02); wr(1'b1, 8'h01);
        run_i = 1'b1;
        for (int i = 0; i < 257; i++) edge_evt(0);
        check("R8 high lane count 257", int'(cnt_o), 257);
        check("R8 no early irq", irq_seen, 2);
        edge_evt(0);
        check("R8 high lane match", int'(cnt_o), 0);
        check("R8 high lane irq", irq_seen, 3);

        // Random sampling rates, compare values and pulse widths
        for (int it = 0; it < 8; it++) begin
            int base;
            int n;
            stop_start();
            mc_div = $urandom_range(1, 4);
            wr(1'b0, 8'($urandom_range(2, 9)));
            wr(1'b1, 8'd0);
            run_i = 1'b1;
            base = irq_seen;
            irq_m = 0;
            n = $urandom_range(1, 20);
            for (int k = 0; k < n; k++) edge_evt($urandom_range(0, 5));
            check("R2 random count", int'(cnt_o), int'(cnt_m));
            check("R6 random irq total", irq_seen - base, irq_m);
        end

        check("R10 irq single-cycle", irq_wide, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule